// File: doc/BRIEF.md
# IO Address Translation Unit

This block turns 32-bit addresses issued by DMA-capable devices into 40-bit physical addresses. The mapping lives in a flat, physically contiguous page directory in system memory: one 64-bit entry per 4 KiB page, indexed by the upper bits of the device address. A small fully associative cache keeps recently used entries, so a repeated page is translated without touching memory. Software controls the unit through a write-only register port. It can open a translation window, set its mask, select the page-size mode, point at the directory and purge cached entries.

A device presents one address at a time through a valid/ready request port. Each accepted request produces exactly one response pulse. The response carries the physical address and the coherence index taken from the entry, or a fault flag. On a cache miss the unit issues a single 64-bit read on its memory port and waits for the returned entry. The entry arrives as an assembled little-endian word: bit 63 is the valid flag, bits 39:12 are the physical page number and bits 7:0 are the coherence index.

Top module: `iotu_top`

## Requirements
- R1: While bit 0 of the window base register (reg_sel 0) is 0, every request completes without a fault, with rsp_pa equal to the zero-extended request address and rsp_ci zero, and no memory read is issued.
- R2: With translation enabled, a request is inside the window when (address AND mask register (reg_sel 1)) equals the window base with bit 0 cleared. A request outside the window completes with a fault and no memory read.
- R3: On a miss, exactly one memory read is issued, at the address directory base (reg_sel 4) + (request address >> 12) × 8. The address is held stable until mem_req_ready.
- R4: For a valid entry, rsp_pa is entry bits 39:12 followed by the low 12 bits of the request address, and rsp_ci is entry bits 7:0.
- R5: An entry with bit 63 clear yields a fault with rsp_pa and rsp_ci zero. It is not cached, so the same page fetches again.
- R6: A request that hits the cache responds in the cycle after acceptance and issues no memory read.
- R7: The cache holds 8 entries and replaces them in round-robin order. After nine distinct pages are fetched, the first of them misses and the second still hits.
- R8: Writing the purge register (reg_sel 3) with page address OR 12 invalidates that page only. Other cached pages still hit.
- R9: Writing the purge register with 31 in bits 4:0 invalidates every cached entry.
- R10: A purge written while a directory read is outstanding still lets the response complete with the fetched translation, but the entry is not cached.
- R11: A nonzero page configuration register (reg_sel 2) makes every in-window translated request fault without a memory read. Zero selects 4 KiB pages.
- R12: After reset, req_ready is 1 and rsp_valid and mem_req_valid are 0. req_ready falls after acceptance until the response, and rsp_valid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 window base, 1 mask, 2 page config, 3 purge, 4 directory base |
| reg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Device request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_iova | input | 32 | Device (IO virtual) address |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_pa | output | 40 | Physical address |
| rsp_ci | output | 8 | Coherence index from the entry |
| mem_req_valid | output | 1 | Directory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Directory entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Directory entry |

## Verification
The bench uses the default parameters: 32-bit device addresses, 40-bit physical addresses, 4 KiB pages and an 8-entry cache. With eight entries, nine distinct pages are enough to force a round-robin eviction and tell an evicted page from a surviving one. The memory model's read latency is adjustable, so a purge can be placed inside an outstanding directory read.

// File: rtl/iotu_pkg.sv
package iotu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } iotu_state_e;

    localparam logic [2:0] SEL_WBASE = 3'd0;
    localparam logic [2:0] SEL_WMASK = 3'd1;
    localparam logic [2:0] SEL_PGCFG = 3'd2;
    localparam logic [2:0] SEL_PURGE = 3'd3;
    localparam logic [2:0] SEL_DBASE = 3'd4;

    localparam logic [4:0] PURGE_ONE_CODE = 5'd12;
    localparam logic [4:0] PURGE_ALL_CODE = 5'd31;
endpackage

// File: rtl/iotu_regs.sv
module iotu_regs
    import iotu_pkg::*;
#(
    parameter int IOVA_W   = 32,
    parameter int PA_W     = 40,
    parameter int DATA_W   = 64,
    parameter int PG_SHIFT = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [2:0]                 sel,
    input  logic [DATA_W-1:0]          wdata,
    output logic [IOVA_W-1:0]          wbase,
    output logic [IOVA_W-1:0]          wmask,
    output logic [IOVA_W-1:0]          pgcfg,
    output logic [PA_W-1:0]            dbase,
    output logic                       purge_one,
    output logic                       purge_all,
    output logic [IOVA_W-PG_SHIFT-1:0] purge_vpn
);
    localparam int VPN_W = IOVA_W - PG_SHIFT;

    typedef struct packed {
        logic [IOVA_W-1:0] wbase;
        logic [IOVA_W-1:0] wmask;
        logic [IOVA_W-1:0] pgcfg;
        logic [PA_W-1:0]   dbase;
        logic              p_one;
        logic              p_all;
        logic [VPN_W-1:0]  p_vpn;
    } regs_t;

    regs_t q, d;

    logic unused_wdata;
    assign unused_wdata = ^{wdata[DATA_W-1:PA_W], wdata[PG_SHIFT-1:5]};

    always_comb begin
        d = q;
        d.p_one = 1'b0;
        d.p_all = 1'b0;
        if (we) begin
            case (sel)
                SEL_WBASE: d.wbase = wdata[IOVA_W-1:0];
                SEL_WMASK: d.wmask = wdata[IOVA_W-1:0];
                SEL_PGCFG: d.pgcfg = wdata[IOVA_W-1:0];
                SEL_DBASE: d.dbase = wdata[PA_W-1:0];
                SEL_PURGE: begin
                    d.p_vpn = wdata[IOVA_W-1:PG_SHIFT];
                    d.p_one = (wdata[4:0] == PURGE_ONE_CODE);
                    d.p_all = (wdata[4:0] == PURGE_ALL_CODE);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wbase     = q.wbase;
    assign wmask     = q.wmask;
    assign pgcfg     = q.pgcfg;
    assign dbase     = q.dbase;
    assign purge_one = q.p_one;
    assign purge_all = q.p_all;
    assign purge_vpn = q.p_vpn;
endmodule

// File: rtl/iotu_cache.sv
module iotu_cache #(
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 28,
    parameter int CI_W    = 8,
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [CI_W-1:0]  lk_ci,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [CI_W-1:0]  ins_ci,
    input  logic             purge_one,
    input  logic [VPN_W-1:0] purge_vpn,
    input  logic             flush
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [ENTRIES-1:0][CI_W-1:0]  ci;
        logic [IDX_W-1:0]              ptr;
    } cache_t;

    cache_t q, d;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] purge_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g]   = q.vld[g] && (q.tag[g] == lk_vpn);
        assign purge_vec[g] = q.vld[g] && (q.tag[g] == purge_vpn);
    end

    always_comb begin
        lk_hit = |hit_vec;
        lk_ppn = '0;
        lk_ci  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                lk_ppn = lk_ppn | q.ppn[i];
                lk_ci  = lk_ci  | q.ci[i];
            end
        end
    end

    always_comb begin
        d = q;
        if (flush)          d.vld = '0;
        else if (purge_one) d.vld = q.vld & ~purge_vec;
        if (ins_en) begin
            d.vld[q.ptr] = 1'b1;
            d.tag[q.ptr] = ins_vpn;
            d.ppn[q.ptr] = ins_ppn;
            d.ci[q.ptr]  = ins_ci;
            d.ptr        = (q.ptr == LAST) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/iotu_top.sv
module iotu_top
    import iotu_pkg::*;
#(
    parameter int IOVA_W   = 32,
    parameter int PA_W     = 40,
    parameter int DATA_W   = 64,
    parameter int PG_SHIFT = 12,
    parameter int CI_W     = 8,
    parameter int ENTRIES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IOVA_W-1:0] req_iova,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [CI_W-1:0]   rsp_ci,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int VPN_W = IOVA_W - PG_SHIFT;
    localparam int PPN_W = PA_W - PG_SHIFT;
    localparam int ESH   = $clog2(DATA_W / 8);
    localparam int IPAD  = PA_W - VPN_W - ESH;

    typedef struct packed {
        iotu_state_e       st;
        logic [IOVA_W-1:0] iova;
        logic              fault;
        logic [PA_W-1:0]   pa;
        logic [CI_W-1:0]   ci;
        logic              drop;
    } top_t;

    top_t q, d;

    logic [IOVA_W-1:0] wbase, wmask, pgcfg;
    logic [PA_W-1:0]   dbase;
    logic              purge_one, purge_all, purge_any;
    logic [VPN_W-1:0]  purge_vpn;
    logic              lk_hit, ins_en, in_win;
    logic [PPN_W-1:0]  lk_ppn;
    logic [CI_W-1:0]   lk_ci;
    logic              unused_entry;

    assign unused_entry = ^{mem_rsp_data[DATA_W-2:PA_W], mem_rsp_data[PG_SHIFT-1:CI_W]};

    iotu_regs #(
        .IOVA_W(IOVA_W), .PA_W(PA_W), .DATA_W(DATA_W), .PG_SHIFT(PG_SHIFT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .wbase(wbase), .wmask(wmask), .pgcfg(pgcfg), .dbase(dbase),
        .purge_one(purge_one), .purge_all(purge_all), .purge_vpn(purge_vpn)
    );

    iotu_cache #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .CI_W(CI_W), .ENTRIES(ENTRIES)
    ) u_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(req_iova[IOVA_W-1:PG_SHIFT]), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_ci(lk_ci),
        .ins_en(ins_en), .ins_vpn(q.iova[IOVA_W-1:PG_SHIFT]),
        .ins_ppn(mem_rsp_data[PA_W-1:PG_SHIFT]), .ins_ci(mem_rsp_data[CI_W-1:0]),
        .purge_one(purge_one), .purge_vpn(purge_vpn), .flush(purge_all)
    );

    assign purge_any = purge_one | purge_all;
    assign in_win    = ((req_iova & wmask) == (wbase & ~IOVA_W'(1)));

    always_comb begin
        d      = q;
        ins_en = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.iova  = req_iova;
                    d.drop  = 1'b0;
                    d.fault = 1'b0;
                    d.pa    = '0;
                    d.ci    = '0;
                    if (!wbase[0]) begin
                        d.pa = {{(PA_W-IOVA_W){1'b0}}, req_iova};
                        d.st = ST_RESP;
                    end else if (!in_win || (pgcfg != '0)) begin
                        d.fault = 1'b1;
                        d.st    = ST_RESP;
                    end else if (lk_hit && !purge_any) begin
                        d.pa = {lk_ppn, req_iova[PG_SHIFT-1:0]};
                        d.ci = lk_ci;
                        d.st = ST_RESP;
                    end else begin
                        d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (purge_any)     d.drop = 1'b1;
                if (mem_req_ready) d.st   = ST_WAIT;
            end
            ST_WAIT: begin
                if (purge_any) d.drop = 1'b1;
                if (mem_rsp_valid) begin
                    d.st = ST_RESP;
                    if (mem_rsp_data[DATA_W-1]) begin
                        d.pa   = {mem_rsp_data[PA_W-1:PG_SHIFT], q.iova[PG_SHIFT-1:0]};
                        d.ci   = mem_rsp_data[CI_W-1:0];
                        ins_en = !(q.drop || purge_any);
                    end else begin
                        d.fault = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign rsp_valid     = (q.st == ST_RESP);
    assign rsp_fault     = q.fault;
    assign rsp_pa        = q.pa;
    assign rsp_ci        = q.ci;
    assign mem_req_valid = (q.st == ST_FETCH);
    assign mem_req_addr  = dbase + {{IPAD{1'b0}}, q.iova[IOVA_W-1:PG_SHIFT], {ESH{1'b0}}};
endmodule

// File: rtl/iotu_chk.sv
module iotu_chk #(
    parameter int PA_W = 40,
    parameter int CI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_pa,
    input logic [CI_W-1:0] rsp_ci,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr
);
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12
    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R12
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && rsp_ci == '0)); // R5
    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R3
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3
    AST_READ_NOT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rsp_valid); // R6
endmodule

bind iotu_top iotu_chk #(.PA_W(PA_W), .CI_W(CI_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_ci(rsp_ci),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/iotu_top_test.sv
`timescale 1ns/1ps
module iotu_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [63:0] reg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_iova = '0;
    logic        rsp_valid, rsp_fault;
    logic [39:0] rsp_pa;
    logic [7:0]  rsp_ci;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [39:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    localparam logic [39:0] DBASE = 40'h00_0100_0000;

    int checks = 0, errors = 0, rd_cnt = 0, mem_lat = 2;
    logic [39:0] rd_addr = '0;
    logic        r_fault;
    logic [39:0] r_pa;
    logic [7:0]  r_ci;
    int          r_lat, r_reads;
    logic        r_pulse_low, r_busy;

    always #2 clk = ~clk;

    iotu_top uut (.*);

    function automatic logic [27:0] ppn_of(input logic [19:0] idx);
        return 28'h00A_0000 + 28'(idx) * 28'd3;
    endfunction

    function automatic logic [63:0] ent(input logic [39:0] idx);
        logic [63:0] e;
        e = '0;
        e[63]    = (idx != 40'd7);
        e[39:12] = ppn_of(idx[19:0]);
        e[7:0]   = idx[7:0] ^ 8'h5A;
        return e;
    endfunction

    function automatic logic [39:0] exp_pa(input logic [31:0] a);
        return {ppn_of(a[31:12]), a[11:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                rd_addr = mem_req_addr;
                rd_cnt++;
                repeat (mem_lat) @(negedge clk);
                mem_rsp_data  = ent((rd_addr - DBASE) >> 3);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    task automatic wr(input logic [2:0] sel, input logic [63:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] a);
        int start;
        start = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_iova = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_busy = !req_ready;
        r_lat  = 1;
        while (!rsp_valid) begin @(negedge clk); r_lat++; end
        r_fault = rsp_fault; r_pa = rsp_pa; r_ci = rsp_ci;
        @(negedge clk);
        r_pulse_low = !rsp_valid;
        r_reads = rd_cnt - start;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R12", "reset ready", 64'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R12", "reset rsp_valid", 64'(rsp_valid), 0);
        chk(mem_req_valid == 1'b0, "R12", "reset mem_req_valid", 64'(mem_req_valid), 0);
    endtask

    task automatic t_passthrough();
        do_req(32'h1234_5678);
        chk(r_fault == 1'b0, "R1", "pass fault", 64'(r_fault), 0);
        chk(r_pa == 40'h00_1234_5678, "R1", "pass pa", 64'(r_pa), 64'h12345678);
        chk(r_ci == 8'h00, "R1", "pass ci", 64'(r_ci), 0);
        chk(r_reads == 0, "R1", "pass reads", 64'(r_reads), 0);
    endtask

    task automatic t_miss_hit();
        do_req(32'h0000_3ABC);
        chk(r_reads == 1, "R3", "miss reads", 64'(r_reads), 1);
        chk(rd_addr == DBASE + 40'h18, "R3", "dir addr", 64'(rd_addr), 64'(DBASE + 40'h18));
        chk(r_pa == exp_pa(32'h3ABC), "R4", "miss pa", 64'(r_pa), 64'(exp_pa(32'h3ABC)));
        chk(r_ci == (8'h03 ^ 8'h5A), "R4", "miss ci", 64'(r_ci), 64'(8'h03 ^ 8'h5A));
        chk(r_busy && r_pulse_low, "R12", "busy/pulse", 64'({r_busy, r_pulse_low}), 64'h3);
        do_req(32'h0000_3004);
        chk(r_reads == 0, "R6", "hit reads", 64'(r_reads), 0);
        chk(r_lat == 1, "R6", "hit latency", 64'(r_lat), 1);
        chk(r_pa == exp_pa(32'h3004), "R6", "hit pa", 64'(r_pa), 64'(exp_pa(32'h3004)));
    endtask

    task automatic t_window();
        do_req(32'h1000_3000);
        chk(r_fault && r_reads == 0, "R2", "outside fault", 64'({r_fault, 8'(r_reads)}), 64'h100);
        wr(3'd0, 64'h2000_0001);
        do_req(32'h2000_5123);
        chk(r_fault == 1'b0, "R2", "moved window fault", 64'(r_fault), 0);
        chk(rd_addr == DBASE + 40'h10_0028, "R2", "moved window addr", 64'(rd_addr),
            64'(DBASE + 40'h10_0028));
        chk(r_pa == exp_pa(32'h2000_5123), "R2", "moved window pa", 64'(r_pa),
            64'(exp_pa(32'h2000_5123)));
        wr(3'd0, 64'h1);
    endtask

    task automatic t_invalid();
        do_req(32'h0000_7010);
        chk(r_fault == 1'b1, "R5", "invalid fault", 64'(r_fault), 1);
        chk(r_pa == '0 && r_ci == '0, "R5", "invalid pa", 64'(r_pa), 0);
        do_req(32'h0000_7010);
        chk(r_reads == 1, "R5", "invalid not cached", 64'(r_reads), 1);
    endtask

    task automatic t_purge_one();
        do_req(32'h0000_4000);
        wr(3'd3, 64'h0000_300C);
        do_req(32'h0000_3000);
        chk(r_reads == 1, "R8", "purged page reads", 64'(r_reads), 1);
        do_req(32'h0000_4000);
        chk(r_reads == 0, "R8", "other page kept", 64'(r_reads), 0);
    endtask

    task automatic t_flush();
        wr(3'd3, 64'd31);
        do_req(32'h0000_4000);
        chk(r_reads == 1, "R9", "flush page4", 64'(r_reads), 1);
        do_req(32'h0000_3000);
        chk(r_reads == 1, "R9", "flush page3", 64'(r_reads), 1);
    endtask

    task automatic t_evict();
        wr(3'd3, 64'd31);
        for (int p = 16; p <= 24; p++) do_req(32'(p) << 12);
        do_req(32'h0001_1000);
        chk(r_reads == 0, "R7", "second page survives", 64'(r_reads), 0);
        do_req(32'h0001_0000);
        chk(r_reads == 1, "R7", "first page evicted", 64'(r_reads), 1);
    endtask

    task automatic t_race();
        int start;
        wr(3'd3, 64'd31);
        mem_lat = 8;
        start = rd_cnt;
        fork
            do_req(32'h0004_0123);
            begin
                wait (rd_cnt != start);
                wr(3'd3, 64'd31);
            end
        join
        chk(r_fault == 1'b0 && r_pa == exp_pa(32'h0004_0123), "R10", "race pa", 64'(r_pa),
            64'(exp_pa(32'h0004_0123)));
        mem_lat = 2;
        do_req(32'h0004_0000);
        chk(r_reads == 1, "R10", "race not cached", 64'(r_reads), 1);
    endtask

    task automatic t_pgcfg();
        wr(3'd2, 64'd1);
        do_req(32'h0000_3000);
        chk(r_fault && r_reads == 0, "R11", "cfg fault", 64'({r_fault, 8'(r_reads)}), 64'h100);
        wr(3'd2, 64'd0);
        do_req(32'h0000_3000);
        chk(r_fault == 1'b0, "R11", "cfg zero ok", 64'(r_fault), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        wr(3'd4, 64'(DBASE));
        wr(3'd1, 64'hF000_0000);
        wr(3'd0, 64'h1);
        t_miss_hit();
        t_window();
        t_invalid();
        t_purge_one();
        t_flush();
        t_evict();
        t_race();
        t_pgcfg();
        finish_up();
    end
endmodule